// File: doc/BRIEF.md
# Flash Region Access Enforcer

This block guards a shared serial flash that several requesters use: a host processor, a management processor and a third agent. After reset it fetches a small permission descriptor from the start of the flash. That descriptor carves the flash into up to five page-aligned regions and says, for each region, which requester may read it and which may write it. From then on every request is checked against its address, its requester ID and its operation. A permitted request passes to the flash port untouched. A refused request never leaves the block and is answered with an error pulse.

The controller is a small state machine:
- `ST_SAMPLE` runs in the first cycle after reset. It captures the service strap and moves to `ST_FETCH`.
- `ST_FETCH` issues a one-cycle read of the next descriptor word and moves to `ST_WAIT`.
- `ST_WAIT` waits for read data. When data arrives it stores the word, then goes back to `ST_FETCH`, or to `ST_CHECK` after the last word.
- `ST_CHECK` tests the signature word. It enters `ST_RUN` when the signature matches and `ST_SAFE` when it does not.
- `ST_RUN` and `ST_SAFE` are terminal until the next reset.

While the strap is captured high, every check is bypassed.

The descriptor can lock itself. Once locked, nobody may rewrite the descriptor region and the host loses all access to it. The management processor's region stays private to it whatever the enable bits say.

Top module: `flash_region_enforcer`

## Requirements
- R1: After reset the block issues exactly seven flash reads, at byte addresses 0, 4, 8, 12, 16, 20 and 24, one word at a time. Until loading ends, `rq_grant_o` and `rq_error_o` stay low whatever the requesters drive.
- R2: Descriptor layout:
  - Word 0 is the signature 0x5AF0C3A5.
  - Word 1 bit 0 is the lock.
  - Word 2+k describes region k (k = 0..4):
    - bits [11:0]: first 4 KB page;
    - bits [23:12]: last 4 KB page, inclusive;
    - bit 24+id: read enable for requester id (0..2);
    - bit 27+id: write enable for requester id (0..2).
- R3: An address matches region k when its page (address bits [23:12]) lies between that region's first and last page. When several regions match, the lowest-numbered one decides. An address that matches no region is rejected.
- R4: In normal mode a request is granted only if the enable bit of the deciding region is set for the request's ID and operation. ID 3 is never granted.
- R5: Region 1 is the management processor's region. Only requester ID 1 is ever granted there, whatever the enable bits of the other IDs say.
- R6: Region 0 is the descriptor region, and writes to it are checked against its own enable bits. When the lock bit is set, every write to region 0 is rejected and requester ID 0 (host) is rejected for reads of region 0 as well.
- R7: If the signature word differs from 0x5AF0C3A5, the block enters a safe mode. In safe mode only reads of page 0 (addresses 0x000000 to 0x000FFF) are granted, from any ID, and every write is rejected.
- R8: If `strap_i` is high in the first clock cycle after reset, every request is granted once loading ends, for any ID, address and operation, regardless of signature, lock or enable bits.
- R9: `strap_i` is sampled only in that first cycle. Changing it later alters no decision until the next reset.
- R10: After loading, the block answers each cycle in which `rq_valid_i` is high in that same cycle with exactly one of `rq_grant_o` and `rq_error_o`. Both stay low when `rq_valid_i` is low.
- R11: A granted request appears on the flash port in the same cycle with identical address, write flag and write data, and `fl_valid_o` high. A rejected request leaves `fl_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Service strap; high bypasses all checks (captured once after reset) |
| rq_valid_i | input | 1 | A request is present this cycle |
| rq_id_i | input | 2 | Requester ID (0 host, 1 management processor, 2 third agent) |
| rq_write_i | input | 1 | 1 = write, 0 = read |
| rq_addr_i | input | 24 | Request byte address |
| rq_wdata_i | input | 32 | Request write data |
| rq_grant_o | output | 1 | Request permitted and forwarded |
| rq_error_o | output | 1 | Request refused |
| fl_valid_o | output | 1 | Flash access strobe |
| fl_write_o | output | 1 | Flash access is a write |
| fl_addr_o | output | 24 | Flash byte address |
| fl_wdata_o | output | 32 | Flash write data |
| fl_rdata_i | input | 32 | Flash read data |
| fl_rvalid_i | input | 1 | Flash read data valid |

## Verification
The bench builds the block with its default parameters: five regions, three requesters and a 24-bit address, which gives 4096 pages. At that size every requester code, including the unused ID 3, can be swept with both operations over a set of pages. The page set lies on and around every region edge, inside an overlap of two regions, in gaps between regions and at the top page.

Each sweep is repeated for an unlocked descriptor, a locked one and one with a bad signature. It is also repeated with the strap captured high and the strap then toggled at runtime, and again with the strap raised only after the capture cycle. These runs put every branch of the permission rules and every terminal state of the controller within reach.

// File: rtl/fre_pkg.sv
package fre_pkg;
    localparam int WORD_W     = 32;
    localparam int PAGE_SHIFT = 12;

    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_FETCH,
        ST_WAIT,
        ST_CHECK,
        ST_RUN,
        ST_SAFE
    } ld_state_e;

    typedef enum logic [1:0] {
        MODE_LOAD,
        MODE_NORMAL,
        MODE_SAFE,
        MODE_BYPASS
    } acc_mode_e;
endpackage

// File: rtl/fre_desc_loader.sv
module fre_desc_loader
    import fre_pkg::*;
#(
    parameter int AW    = 24,
    parameter int NREG  = 5,
    parameter int NREQ  = 3,
    parameter logic [WORD_W-1:0] SIG = 32'h5AF0_C3A5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           strap_i,
    output logic                           rd_valid_o,
    output logic [AW-1:0]                  rd_addr_o,
    input  logic [WORD_W-1:0]              rd_data_i,
    input  logic                           rd_ack_i,
    output acc_mode_e                      mode_o,
    output logic                           lock_o,
    output logic [NREG-1:0][2*(AW-PAGE_SHIFT)+2*NREQ-1:0] regions_o
);
    localparam int PW   = AW - PAGE_SHIFT;
    localparam int REGW = 2*PW + 2*NREQ;
    localparam int NW   = 2 + NREG;
    localparam int IW   = $clog2(NW + 1);

    ld_state_e                  state_q;
    logic [IW-1:0]              idx_q;
    logic                       strap_q;
    logic                       lock_q;
    logic [WORD_W-1:0]          sig_q;
    logic [NREG-1:0][REGW-1:0]  reg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
            idx_q   <= '0;
            strap_q <= 1'b0;
            lock_q  <= 1'b0;
            sig_q   <= '0;
            reg_q   <= '0;
        end else begin
            unique case (state_q)
                ST_SAMPLE: begin
                    strap_q <= strap_i;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rd_ack_i) begin
                        if (idx_q == IW'(0)) sig_q <= rd_data_i;
                        if (idx_q == IW'(1)) lock_q <= rd_data_i[0];
                        for (int r = 0; r < NREG; r++) begin
                            if (idx_q == IW'(r + 2)) reg_q[r] <= rd_data_i[REGW-1:0];
                        end
                        if (idx_q == IW'(NW - 1)) begin
                            state_q <= ST_CHECK;
                        end else begin
                            idx_q   <= idx_q + IW'(1);
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_CHECK: state_q <= (sig_q == SIG) ? ST_RUN : ST_SAFE;
                ST_RUN:   state_q <= ST_RUN;
                ST_SAFE:  state_q <= ST_SAFE;
                default:  state_q <= ST_SAMPLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_valid_o = (state_q == ST_FETCH);
        rd_addr_o  = AW'(idx_q) << 2;
        lock_o     = lock_q;
        regions_o  = reg_q;
        unique case (state_q)
            ST_RUN:  mode_o = strap_q ? MODE_BYPASS : MODE_NORMAL;
            ST_SAFE: mode_o = strap_q ? MODE_BYPASS : MODE_SAFE;
            default: mode_o = MODE_LOAD;
        endcase
    end

    // R9: strap value frozen after the capture cycle
    p_strap_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SAMPLE) |=> $stable(strap_q));

    // R1: each non-final word received leads to the next word read, 4 bytes on
    p_fetch_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && rd_ack_i && idx_q != IW'(NW - 1))
        |=> (rd_valid_o && rd_addr_o == $past(rd_addr_o) + AW'(4)));

    // R1: terminal states are never left
    p_terminal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN || state_q == ST_SAFE) |=> $stable(state_q));
endmodule

// File: rtl/fre_rule_check.sv
module fre_rule_check
    import fre_pkg::*;
#(
    parameter int AW        = 24,
    parameter int NREG      = 5,
    parameter int NREQ      = 3,
    parameter int IDW       = 2,
    parameter int HOST_ID   = 0,
    parameter int ME_ID     = 1,
    parameter int ME_REGION = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  acc_mode_e                      mode_i,
    input  logic                           lock_i,
    input  logic [NREG-1:0][2*(AW-PAGE_SHIFT)+2*NREQ-1:0] regions_i,
    input  logic                           valid_i,
    input  logic [IDW-1:0]                 id_i,
    input  logic                           write_i,
    input  logic [AW-1:0]                  addr_i,
    output logic                           allow_o
);
    localparam int PW     = AW - PAGE_SHIFT;
    localparam int RD_LSB = 2*PW;
    localparam int WR_LSB = 2*PW + NREQ;
    localparam int RW     = (NREG > 1) ? $clog2(NREG) : 1;

    logic [PW-1:0]   page;
    logic [NREG-1:0] hit;
    logic [NREG-1:0] rd_sel;
    logic [NREG-1:0] wr_sel;
    logic [RW-1:0]   win;
    logic            any_hit;
    logic            owner_ok;
    logic            lock_ok;
    logic            norm_ok;

    assign page = addr_i[AW-1:PAGE_SHIFT];

    for (genvar r = 0; r < NREG; r++) begin : g_region
        logic [PW-1:0] first_pg;
        logic [PW-1:0] last_pg;
        assign first_pg = regions_i[r][PW-1:0];
        assign last_pg  = regions_i[r][2*PW-1:PW];
        assign hit[r]   = (page >= first_pg) && (page <= last_pg);
    end

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            rd_sel[r] = 1'b0;
            wr_sel[r] = 1'b0;
            for (int q = 0; q < NREQ; q++) begin
                if (id_i == IDW'(q)) begin
                    rd_sel[r] = regions_i[r][RD_LSB + q];
                    wr_sel[r] = regions_i[r][WR_LSB + q];
                end
            end
        end
    end

    // Lowest-numbered matching region wins
    always_comb begin
        win     = '0;
        any_hit = 1'b0;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (hit[r]) begin
                win     = RW'(r);
                any_hit = 1'b1;
            end
        end
    end

    always_comb begin
        owner_ok = !(win == RW'(ME_REGION) && id_i != IDW'(ME_ID));
        lock_ok  = !(win == '0 && lock_i && (write_i || id_i == IDW'(HOST_ID)));
        norm_ok  = any_hit && owner_ok && lock_ok && (write_i ? wr_sel[win] : rd_sel[win]);
        unique case (mode_i)
            MODE_BYPASS: allow_o = 1'b1;
            MODE_SAFE:   allow_o = !write_i && (page == '0);
            MODE_NORMAL: allow_o = norm_ok;
            default:     allow_o = 1'b0;
        endcase
    end

    // R3: no matching region means no grant in normal mode
    p_nomatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i == MODE_NORMAL && hit == '0) |-> !allow_o);

    // R5: private region only reachable by its owner
    p_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && allow_o && mode_i == MODE_NORMAL && hit[ME_REGION]
         && (hit & ((NREG'(1) << ME_REGION) - NREG'(1))) == '0)
        |-> (id_i == IDW'(ME_ID)));

    // R6: locked descriptor region: no writes, no host access
    p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && allow_o && mode_i == MODE_NORMAL && lock_i && hit[0])
        |-> (!write_i && id_i != IDW'(HOST_ID)));

    // R7: safe mode allows page-0 reads only
    p_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && allow_o && mode_i == MODE_SAFE) |-> (!write_i && addr_i < AW'(1 << PAGE_SHIFT)));
endmodule

// File: rtl/flash_region_enforcer.sv
module flash_region_enforcer
    import fre_pkg::*;
#(
    parameter int AW        = 24,
    parameter int NREG      = 5,
    parameter int NREQ      = 3,
    parameter int IDW       = 2,
    parameter int HOST_ID   = 0,
    parameter int ME_ID     = 1,
    parameter int ME_REGION = 1,
    parameter logic [31:0] SIG = 32'h5AF0_C3A5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strap_i,
    input  logic           rq_valid_i,
    input  logic [IDW-1:0] rq_id_i,
    input  logic           rq_write_i,
    input  logic [AW-1:0]  rq_addr_i,
    input  logic [31:0]    rq_wdata_i,
    output logic           rq_grant_o,
    output logic           rq_error_o,
    output logic           fl_valid_o,
    output logic           fl_write_o,
    output logic [AW-1:0]  fl_addr_o,
    output logic [31:0]    fl_wdata_o,
    input  logic [31:0]    fl_rdata_i,
    input  logic           fl_rvalid_i
);
    localparam int PW   = AW - PAGE_SHIFT;
    localparam int REGW = 2*PW + 2*NREQ;

    acc_mode_e                 mode;
    logic                      lock;
    logic [NREG-1:0][REGW-1:0] regions;
    logic                      ld_valid;
    logic [AW-1:0]             ld_addr;
    logic                      allow;
    logic                      loading;

    fre_desc_loader #(
        .AW(AW), .NREG(NREG), .NREQ(NREQ), .SIG(SIG)
    ) u_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_i    (strap_i),
        .rd_valid_o (ld_valid),
        .rd_addr_o  (ld_addr),
        .rd_data_i  (fl_rdata_i),
        .rd_ack_i   (fl_rvalid_i),
        .mode_o     (mode),
        .lock_o     (lock),
        .regions_o  (regions)
    );

    fre_rule_check #(
        .AW(AW), .NREG(NREG), .NREQ(NREQ), .IDW(IDW),
        .HOST_ID(HOST_ID), .ME_ID(ME_ID), .ME_REGION(ME_REGION)
    ) u_rules (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .lock_i    (lock),
        .regions_i (regions),
        .valid_i   (rq_valid_i),
        .id_i      (rq_id_i),
        .write_i   (rq_write_i),
        .addr_i    (rq_addr_i),
        .allow_o   (allow)
    );

    always_comb begin
        loading    = (mode == MODE_LOAD);
        rq_grant_o = !loading && rq_valid_i && allow;
        rq_error_o = !loading && rq_valid_i && !allow;
        fl_valid_o = loading ? ld_valid : rq_grant_o;
        fl_write_o = !loading && rq_write_i;
        fl_addr_o  = loading ? ld_addr : rq_addr_i;
        fl_wdata_o = rq_wdata_i;
    end

    // R1: requests stalled while the descriptor loads
    p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        loading |-> (!rq_grant_o && !rq_error_o));

    // R10: exactly one answer per valid request after load, none otherwise
    p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid_i && !loading) |-> (rq_grant_o != rq_error_o));
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rq_valid_i |-> (!rq_grant_o && !rq_error_o));

    // R11: refused requests never reach the flash; granted ones pass unchanged
    p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rq_error_o |-> !fl_valid_o);
    p_forward_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rq_grant_o |-> (fl_valid_o && fl_addr_o == rq_addr_i
                        && fl_write_o == rq_write_i && fl_wdata_o == rq_wdata_i));
endmodule

// File: tb/flash_region_enforcer_tb.sv
`timescale 1ns/1ps
module flash_region_enforcer_tb;
    localparam int SIGV = 32'h5AF0_C3A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        rq_valid = 1'b0;
    logic [1:0]  rq_id = '0;
    logic        rq_write = 1'b0;
    logic [23:0] rq_addr = '0;
    logic [31:0] rq_wdata = '0;
    logic        grant, err;
    logic        fl_valid, fl_write;
    logic [23:0] fl_addr;
    logic [31:0] fl_wdata;
    logic [31:0] fl_rdata = '0;
    logic        fl_rvalid = 1'b0;

    logic [31:0] mem [8];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit in_load = 0;
    int nreads = 0;
    int bad_read_addr = 0;
    bit strap_at_reset = 0;

    always #4 clk = ~clk;

    flash_region_enforcer u_dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap),
        .rq_valid_i(rq_valid), .rq_id_i(rq_id), .rq_write_i(rq_write),
        .rq_addr_i(rq_addr), .rq_wdata_i(rq_wdata),
        .rq_grant_o(grant), .rq_error_o(err),
        .fl_valid_o(fl_valid), .fl_write_o(fl_write), .fl_addr_o(fl_addr),
        .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata), .fl_rvalid_i(fl_rvalid)
    );

    // Flash model: one-cycle read latency, writes ignored
    always @(posedge clk) begin
        fl_rvalid <= fl_valid && !fl_write;
        fl_rdata  <= mem[fl_addr[4:2]];
        if (in_load && fl_valid) begin
            if (fl_addr != 24'(nreads * 4)) bad_read_addr++;
            nreads <= nreads + 1;
        end
    end

    function automatic logic [31:0] mkreg(int first, int last, int rd, int wr);
        return (32'(wr) << 27) | (32'(rd) << 24) | (32'(last) << 12) | 32'(first);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected decision computed from the requirement text
    function automatic bit model(int id, bit wr, int page, bit byp, output string tag);
        int hitr = -1;
        logic [31:0] w;
        if (byp) begin tag = "R8"; return 1'b1; end
        if (mem[0] != SIGV) begin tag = "R7"; return !wr && page == 0; end
        for (int r = 4; r >= 0; r--) begin
            w = mem[2 + r];
            if (page >= int'(w[11:0]) && page <= int'(w[23:12])) hitr = r;
        end
        if (hitr < 0) begin tag = "R3"; return 1'b0; end
        if (id > 2) begin tag = "R4"; return 1'b0; end
        if (hitr == 1 && id != 1) begin tag = "R5"; return 1'b0; end
        if (hitr == 0 && mem[1][0] && (wr || id == 0)) begin tag = "R6"; return 1'b0; end
        w = mem[2 + hitr];
        tag = "R2,R4";
        return wr ? w[27 + id] : w[24 + id];
    endfunction

    task automatic do_reset(bit s);
        @(negedge clk);
        rst_n = 1'b0;
        rq_valid = 1'b0;
        strap = s;
        strap_at_reset = s;
        repeat (3) @(negedge clk);
        chk(!grant && !err, "R1", "grant/error in reset", {grant, err}, 0);
        nreads = 0;
        bad_read_addr = 0;
        in_load = 1;
        rst_n = 1'b1;
        // Requests during load must stall
        rq_valid = 1'b1; rq_write = 1'b1; rq_id = 2'd2; rq_addr = 24'h000010;
        for (int c = 0; c < 12; c++) begin
            #2;
            chk(!grant && !err, "R1", "answer during load", {grant, err}, 0);
            @(negedge clk);
        end
        rq_valid = 1'b0;
        repeat (10) @(negedge clk);
        in_load = 0;
        chk(nreads == 7, "R1", "descriptor read count", nreads, 7);
        chk(bad_read_addr == 0, "R1", "descriptor read addresses", bad_read_addr, 0);
    endtask

    task automatic sweep(bit byp, string force_tag);
        int pages [15] = '{0, 1, 'hF, 'h10, 'h3F, 'h40, 'h7F, 'h80, 'hFF,
                           'h100, 'h1FF, 'h200, 'h2FF, 'h300, 'hFFF};
        string tag;
        bit exp;
        for (int id = 0; id < 4; id++) begin
            for (int wr = 0; wr < 2; wr++) begin
                foreach (pages[i]) begin
                    @(negedge clk);
                    rq_valid = 1'b1;
                    rq_id    = 2'(id);
                    rq_write = wr[0];
                    rq_addr  = 24'((pages[i] << 12) | ((pages[i] * 37 + id) & 'hFFC));
                    rq_wdata = 32'hA500_0000 ^ 32'(i * 7 + id);
                    exp = model(id, wr[0], pages[i], byp, tag);
                    if (force_tag != "") tag = force_tag;
                    #2;
                    chk(grant == exp && err == !exp, tag, "grant/error",
                        {grant, err}, {exp, !exp});
                    if (exp)
                        chk(fl_valid && fl_addr == rq_addr && fl_write == wr[0] && fl_wdata == rq_wdata,
                            "R11", "forwarded fields", fl_addr, rq_addr);
                    else
                        chk(!fl_valid, "R11", "rejected reaches flash", fl_valid, 0);
                end
            end
        end
        @(negedge clk);
        rq_valid = 1'b0;
        #2;
        chk(!grant && !err, "R10", "answer without valid", {grant, err}, 0);
    endtask

    task automatic load_regions(logic [31:0] r0);
        mem[2] = r0;
        mem[3] = mkreg('h001, 'h00F, 7, 7);   // private region, all bits set
        mem[4] = mkreg('h010, 'h07F, 3, 1);
        mem[5] = mkreg('h040, 'h0FF, 6, 6);   // overlaps the region above
        mem[6] = mkreg('h200, 'h2FF, 5, 2);
        mem[7] = 32'h0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        // Unlocked, valid descriptor: R2 R3 R4 R5
        mem[0] = SIGV; mem[1] = 32'h0;
        load_regions(mkreg(0, 0, 7, 4));
        do_reset(1'b0);
        sweep(1'b0, "");

        // Locked descriptor: R6
        mem[1] = 32'h1;
        load_regions(mkreg(0, 0, 7, 7));
        do_reset(1'b0);
        sweep(1'b0, "");

        // Bad signature: R7
        mem[0] = 32'hDEAD_0000;
        do_reset(1'b0);
        sweep(1'b0, "");

        // Strap high at reset with bad, locked descriptor: R8
        do_reset(1'b1);
        sweep(1'b1, "");
        // Strap dropped at runtime: still bypassed (R9)
        strap = 1'b0;
        sweep(1'b1, "R9");

        // Strap raised after the capture cycle has no effect (R9)
        mem[0] = SIGV; mem[1] = 32'h0;
        load_regions(mkreg(0, 0, 7, 4));
        do_reset(1'b0);
        strap = 1'b1;
        sweep(1'b0, "R9");
        strap = 1'b0;

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule